// File: doc/BRIEF.md
# Register Access Serial Slave

This block gives an external serial master read and write access to a bank of 32 byte-wide registers. The master frames every transaction with an active-low select. The first byte it sends is a command byte that names a register, the transfer direction and an acknowledge flag. Any number of data bytes then follow in the same transaction. After each data byte the internal register pointer either stays where it is or moves to the next register, depending on which register is being accessed. Holding the pointer lets the master stream many bytes through one queue-type register. Advancing it lets the master sweep a block of control registers in a single burst.

The serial pins are oversampled in the system clock domain. Toward the register bank the block issues a one-cycle write strobe with address and data, and a one-cycle read strobe whose address stays on `reg_addr` until the next strobe. A mode input selects one of two wirings. In full duplex, separate input and output lines are used, and a status byte supplied by the surrounding logic is returned while the command byte arrives. In half duplex, the single data-in line is also driven by the block during read data.

Top module: `spi_regslave`

## Requirements
- R1: The command byte is shifted in most significant bit first. Bits 7..3 hold the register number, bit 2 is zero, bit 1 is the direction (1 = write, 0 = read) and bit 0 is the acknowledge flag.
- R2: Each complete data byte of a write transaction produces a single-cycle `reg_we` with `reg_addr` and `reg_wdata`. `reg_we` and `reg_re` are never high together.
- R3: In a read transaction, `reg_re` pulses with the command's address once the command byte completes, and again with the next address after each data byte. `reg_rdata` must follow `reg_addr` combinationally. Each read byte is shifted out most significant bit first. The output changes on SCLK falling edges, and the first bit appears on the falling edge that follows the last rising edge of the previous byte.
- R4: After each data byte, the address stays the same for registers 0 to 4, 20 and 31, and increases by one for registers 5 to 19 and 21 to 30.
- R5: In full duplex (`half_duplex` = 0), `status_i` is captured when select falls and is shifted out on `miso_o` during the command byte. `miso_oe` is high while select is low.
- R6: In half duplex, `miso_oe` stays low. `mosi_oe` rises only in the data phase of a read and falls when select rises.
- R7: While select is high, SCLK and data-in toggles have no effect, no strobe is issued and both output enables are low.
- R8: If select rises before the eighth bit of a byte, that byte is dropped and no strobe is issued for it.
- R9: A command byte with the acknowledge flag set pulses `ack_set` for one cycle when `host_mode` = 0, and does nothing when `host_mode` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_duplex | input | 1 | 1 = shared data line, 0 = separate lines |
| host_mode | input | 1 | 1 = acknowledge flag ignored |
| sclk | input | 1 | Serial clock from master, idle low |
| ss_n | input | 1 | Active-low select |
| mosi_i | input | 1 | Serial data in |
| mosi_o | output | 1 | Serial data out on the shared line (half duplex) |
| mosi_oe | output | 1 | Drive enable for the shared line |
| miso_o | output | 1 | Serial data out (full duplex) |
| miso_oe | output | 1 | Drive enable for the output line |
| status_i | input | 8 | Status byte returned during the command |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read strobe |
| reg_addr | output | 5 | Register address of the latest strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data for `reg_addr` |
| ack_set | output | 1 | Acknowledge pulse |

## Verification
The assertions assume the master idles SCLK low when select falls. They also assume each SCLK phase lasts at least four system clocks, so that two byte completions are never closer than a few cycles. The stimulus holds every SCLK phase for eight clocks and waits eight clocks after select falls before the first edge. It changes data only while SCLK is low. The register bank model in the stimulus answers `reg_rdata` combinationally from `reg_addr`, which matches the read timing assumed by R3.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 8;
  localparam int QUEUE_HI = 4;
  localparam int PIN_REG  = 20;
  localparam int TOP_REG  = 31;
  localparam int DIR_BIT  = 1;
  localparam int ACK_BIT  = 0;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CMD  = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    if (a <= ADDR_W'(QUEUE_HI) || a == ADDR_W'(PIN_REG) || a == ADDR_W'(TOP_REG))
      return a;
    else
      return a + ADDR_W'(1);
  endfunction
endpackage

// File: rtl/spi_regslave_sync.sv
module spi_regslave_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= {stg_q[STAGES-2:0], d};
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_regslave_shift.sv
module spi_regslave_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          ss_n_s,
  input  logic          mosi_s,
  input  logic          half_duplex,
  input  logic          load_rd,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] rdata,
  output logic          sel_act,
  output logic          byte_done,
  output logic [DW-1:0] rx_byte,
  output logic          tx_bit,
  output logic          hd_drive
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          sclk_d, ss_d;
  logic          rise, fall, start;
  logic [CW-1:0] bit_q, bit_n;
  logic [DW-2:0] rx_q, rx_n;
  logic [DW-1:0] tx_q, tx_n;
  logic          drv_q, drv_n;

  assign sel_act   = ~ss_n_s;
  assign rise      = sel_act & sclk_s & ~sclk_d;
  assign fall      = sel_act & ~sclk_s & sclk_d;
  assign start     = ss_d & ~ss_n_s;
  assign rx_byte   = {rx_q, mosi_s};
  assign byte_done = rise & (bit_q == LAST);
  assign tx_bit    = tx_q[DW-1];
  assign hd_drive  = drv_q;

  always_comb begin
    bit_n = bit_q;
    rx_n  = rx_q;
    tx_n  = tx_q;
    drv_n = drv_q;
    if (!sel_act) begin
      bit_n = '0;
      drv_n = 1'b0;
    end
    if (start) begin
      tx_n  = status_i;
      bit_n = '0;
    end
    if (rise) begin
      rx_n  = rx_byte[DW-2:0];
      bit_n = bit_q + CW'(1);
    end
    if (fall) begin
      if (bit_q == '0 && load_rd) begin
        tx_n  = rdata;
        drv_n = half_duplex;
      end else begin
        tx_n  = {tx_q[DW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      ss_d   <= 1'b1;
      bit_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      drv_q  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      ss_d   <= ss_n_s;
      bit_q  <= bit_n;
      rx_q   <= rx_n;
      tx_q   <= tx_n;
      drv_q  <= drv_n;
    end
  end
endmodule

// File: rtl/spi_regslave_seq.sv
module spi_regslave_seq
  import spi_regslave_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_act,
  input  logic          byte_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          host_mode,
  output logic          reg_we,
  output logic          reg_re,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          ack_set,
  output logic          load_rd
);
  phase_e        phase_q, phase_n;
  logic          wr_q, wr_n;
  logic [AW-1:0] cur_q, cur_n, cmd_addr;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] wdata_q, wdata_n;
  logic          we_q, we_n, re_q, re_n, ack_q, ack_n;

  assign cmd_addr = rx_byte[DW-1 -: AW];
  assign load_rd  = (phase_q == PH_DATA) & ~wr_q;

  always_comb begin
    phase_n = phase_q;
    wr_n    = wr_q;
    cur_n   = cur_q;
    addr_n  = addr_q;
    wdata_n = wdata_q;
    we_n    = 1'b0;
    re_n    = 1'b0;
    ack_n   = 1'b0;
    if (!sel_act) begin
      phase_n = PH_IDLE;
    end else begin
      if (phase_q == PH_IDLE) phase_n = PH_CMD;
      if (byte_done) begin
        if (phase_q != PH_DATA) begin
          phase_n = PH_DATA;
          cur_n   = cmd_addr;
          wr_n    = rx_byte[DIR_BIT];
          ack_n   = rx_byte[ACK_BIT] & ~host_mode;
          if (!rx_byte[DIR_BIT]) begin
            re_n   = 1'b1;
            addr_n = cmd_addr;
          end
        end else if (wr_q) begin
          we_n    = 1'b1;
          addr_n  = cur_q;
          wdata_n = rx_byte;
          cur_n   = step_addr(cur_q);
        end else begin
          re_n    = 1'b1;
          addr_n  = step_addr(cur_q);
          cur_n   = step_addr(cur_q);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wr_q    <= 1'b0;
      cur_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      phase_q <= phase_n;
      wr_q    <= wr_n;
      cur_q   <= cur_n;
      addr_q  <= addr_n;
      wdata_q <= wdata_n;
      we_q    <= we_n;
      re_q    <= re_n;
      ack_q   <= ack_n;
    end
  end

  assign reg_we    = we_q;
  assign reg_re    = re_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign ack_set   = ack_q;
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
  import spi_regslave_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          half_duplex,
  input  logic          host_mode,
  input  logic          sclk,
  input  logic          ss_n,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic [DW-1:0] status_i,
  output logic          reg_we,
  output logic          reg_re,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata,
  output logic          ack_set
);
  logic       rst_meta, rst_sync;
  logic [2:0] pins_s;
  logic       sel_act, byte_done, tx_bit, hd_drive, load_rd;
  logic [DW-1:0] rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  spi_regslave_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_sync), .d({sclk, ss_n, mosi_i}), .q(pins_s)
  );

  spi_regslave_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_sync),
    .sclk_s(pins_s[2]), .ss_n_s(pins_s[1]), .mosi_s(pins_s[0]),
    .half_duplex(half_duplex), .load_rd(load_rd),
    .status_i(status_i), .rdata(reg_rdata),
    .sel_act(sel_act), .byte_done(byte_done), .rx_byte(rx_byte),
    .tx_bit(tx_bit), .hd_drive(hd_drive)
  );

  spi_regslave_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_sync),
    .sel_act(sel_act), .byte_done(byte_done), .rx_byte(rx_byte),
    .host_mode(host_mode),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ack_set(ack_set), .load_rd(load_rd)
  );

  assign miso_o  = tx_bit;
  assign mosi_o  = tx_bit;
  assign miso_oe = sel_act & ~half_duplex;
  assign mosi_oe = sel_act & half_duplex & hd_drive;
endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk (
  input logic clk,
  input logic rst_n,
  input logic half_duplex,
  input logic host_mode,
  input logic sel_act,
  input logic reg_we,
  input logic reg_re,
  input logic mosi_oe,
  input logic miso_oe,
  input logic ack_set
);
  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));

  // R2
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R6
  shared_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mosi_oe |-> (half_duplex && !miso_oe));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_act |=> (!reg_we && !reg_re && !ack_set));

  // R9
  ack_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_set |-> !$past(host_mode));

  // R9
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_set |=> !ack_set);
endmodule

bind spi_regslave spi_regslave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .half_duplex(half_duplex), .host_mode(host_mode),
  .sel_act(sel_act), .reg_we(reg_we), .reg_re(reg_re),
  .mosi_oe(mosi_oe), .miso_oe(miso_oe), .ack_set(ack_set)
);

// File: tb/sim_spi_regslave.sv
`timescale 1ns/1ps
module sim_spi_regslave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_duplex = 1'b0, host_mode = 1'b0;
  logic sclk = 1'b0, ss_n = 1'b1, b_mosi = 1'b0, b_oe = 1'b1;
  logic mosi_o, mosi_oe, miso_o, miso_oe;
  logic [7:0] status_i = 8'h00;
  logic reg_we, reg_re, ack_set;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic mosi_line;

  int tests = 0, fails = 0;
  logic [7:0] mem [32];
  logic [7:0] wbuf [4];
  logic [7:0] rbuf [4];
  logic [7:0] stat_rx;

  typedef struct { int kind; int addr; int data; string req; } item_t;
  item_t exp_q[$];

  always #4 clk = ~clk;

  assign mosi_line = b_oe ? b_mosi : (mosi_oe ? mosi_o : 1'b1);
  always_comb reg_rdata = mem[reg_addr];

  spi_regslave u0 (
    .clk(clk), .rst_n(rst_n), .half_duplex(half_duplex), .host_mode(host_mode),
    .sclk(sclk), .ss_n(ss_n), .mosi_i(mosi_line), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_o(miso_o), .miso_oe(miso_oe), .status_i(status_i),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ack_set(ack_set)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] nxt(input logic [4:0] a);
    // R4: hold for 0..4, 20, 31; otherwise +1
    if (a <= 5'd4 || a == 5'd20 || a == 5'd31) return a;
    return a + 5'd1;
  endfunction

  task automatic push(input int k, input int a, input int d, input string req);
    item_t it;
    it.kind = k; it.addr = a; it.data = d; it.req = req;
    exp_q.push_back(it);
  endtask

  // monitor: kind 0 = write, 1 = read, 2 = ack
  task automatic observe(input int k, input int a, input int d);
    item_t it;
    tests++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R7 unexpected strobe actual=%0d/%0h/%0h expected=none", k, a, d);
    end else begin
      it = exp_q.pop_front();
      if (it.kind != k || it.addr != a || it.data != d) begin
        fails++;
        $display("FAIL %s actual=%0d/%0h/%0h expected=%0d/%0h/%0h",
                 it.req, k, a, d, it.kind, it.addr, it.data);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_we) begin
        observe(0, reg_addr, reg_wdata);
        mem[reg_addr] = reg_wdata;
      end
      if (ack_set) observe(2, 0, 0);
      if (reg_re)  observe(1, reg_addr, 0);
    end
  end

  task automatic spi_byte(input logic [7:0] tx, input bit drive, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      b_oe = drive;
      b_mosi = tx[i];
      repeat (8) @(negedge clk);
      rx[i] = half_duplex ? mosi_line : miso_o;
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic txn(input logic [4:0] a, input bit wr, input bit ack, input int n);
    logic [4:0] x;
    logic [7:0] expd [4];
    logic [7:0] dummy;
    x = a;
    if (ack && !host_mode) push(2, 0, 0, "R9");
    if (wr) begin
      for (int i = 0; i < n; i++) begin
        push(0, x, wbuf[i], "R2");
        x = nxt(x);
      end
    end else begin
      push(1, x, 0, "R3");
      for (int i = 0; i < n; i++) begin
        expd[i] = mem[x];
        x = nxt(x);
        push(1, x, 0, "R4");
      end
    end
    ss_n = 1'b0;
    repeat (8) @(negedge clk);
    spi_byte({a, 1'b0, wr, ack}, 1'b1, stat_rx);
    for (int i = 0; i < n; i++) begin
      spi_byte(wr ? wbuf[i] : 8'h00, wr || !half_duplex, dummy);
      rbuf[i] = dummy;
    end
    repeat (4) @(negedge clk);
    if (half_duplex) chk("R6", {31'd0, miso_oe}, 32'd0);
    ss_n = 1'b1;
    b_oe = 1'b1;
    repeat (12) @(negedge clk);
    chk("R6", {31'd0, mosi_oe}, 32'd0);
    if (!wr) for (int i = 0; i < n; i++) chk("R3", rbuf[i], expd[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] dmy;
    for (int i = 0; i < 32; i++) mem[i] = 8'(i * 29 + 7);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R7 reset state
    chk("R7", {27'd0, reg_we, reg_re, ack_set, miso_oe, mosi_oe}, 32'd0);

    // R1 R5 full duplex write burst that advances
    status_i = 8'h5C;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    txn(5'd6, 1'b1, 1'b0, 3);
    chk("R5", stat_rx, 8'h5C);
    status_i = 8'hA3;
    // R4 holding register
    wbuf[0] = 8'h44; wbuf[1] = 8'h55; wbuf[2] = 8'h66;
    txn(5'd2, 1'b1, 1'b0, 3);
    chk("R5", stat_rx, 8'hA3);
    // R4 boundaries
    wbuf[0] = 8'h77; wbuf[1] = 8'h88; wbuf[2] = 8'h99;
    txn(5'd19, 1'b1, 1'b0, 3);
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
    txn(5'd30, 1'b1, 1'b0, 3);
    // R3 full duplex read burst
    txn(5'd6, 1'b0, 1'b0, 3);
    txn(5'd3, 1'b0, 1'b0, 2);
    // R9 acknowledge in both modes
    wbuf[0] = 8'h5A;
    txn(5'd9, 1'b1, 1'b1, 1);
    host_mode = 1'b1;
    txn(5'd9, 1'b1, 1'b1, 1);
    txn(5'd12, 1'b0, 1'b1, 1);
    host_mode = 1'b0;
    // R6 half duplex read and write
    half_duplex = 1'b1;
    txn(5'd20, 1'b0, 1'b0, 2);
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
    txn(5'd13, 1'b1, 1'b0, 2);
    txn(5'd13, 1'b0, 1'b1, 2);
    half_duplex = 1'b0;
    // R8 partial byte
    push(0, 10, 8'h3C, "R8"); exp_q.delete();
    ss_n = 1'b0;
    repeat (8) @(negedge clk);
    spi_byte({5'd10, 1'b0, 1'b1, 1'b0}, 1'b1, dmy);
    for (int i = 0; i < 3; i++) begin
      b_mosi = i[0];
      repeat (8) @(negedge clk); sclk = 1'b1;
      repeat (8) @(negedge clk); sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    ss_n = 1'b1;
    repeat (12) @(negedge clk);
    chk("R8", exp_q.size(), 0);
    txn(5'd10, 1'b0, 1'b0, 1);
    chk("R8", rbuf[0], 8'(10 * 29 + 7));
    // R7 select high: clock and data ignored
    for (int i = 0; i < 20; i++) begin
      b_mosi = ~b_mosi;
      repeat (4) @(negedge clk); sclk = 1'b1;
      repeat (4) @(negedge clk); sclk = 1'b0;
      if (i % 5 == 0) chk("R7", {30'd0, miso_oe, mosi_oe}, 32'd0);
    end
    repeat (8) @(negedge clk);
    txn(5'd7, 1'b0, 1'b0, 1);
    chk("R7", rbuf[0], 8'h22);
    chk("R2", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule